// File: doc/BRIEF.md
# Biased Carrier NCO with Sine/Cosine Map

This block is the replica carrier oscillator for a tracking loop. A constant bias word sets the nominal frequency. A signed correction from the loop filter is sign-extended and added to the bias, and the sum is registered as the frequency word. On each enabled clock a 32-bit phase accumulator advances by that word. The output frequency is the word times the clock rate divided by 2^32, so the step size is the clock rate over 2^32 (about 0.0466 Hz at 200 MHz). A 10.23 MHz output at a 200 MHz clock needs a bias of about 2.1969e8.

The top bits of the accumulator index a small level table. This turns the staircase phase into coarse in-phase and quadrature values for the downstream mixers. Each wrap of the accumulator marks one completed replica cycle and produces a one-clock strobe. The loop filter and the mixers sit outside this block.

Top module: `carrier_nco`

## Requirements
- R1: A synchronous active-low reset clears the phase, the overflow strobe and the registered frequency word to zero. In the first clock after reset is released, the phase therefore stays at zero.
- R2: The frequency word is bias_i plus corr_i sign-extended to 32 bits, taken modulo 2^32. It is registered on every clock, whatever the enable, and is used by the accumulator one clock later.
- R3: On each clock with en high, phase_o becomes the previous phase plus the registered frequency word, modulo 2^32.
- R4: ovf_o is high for exactly the clock in which phase_o shows a value produced by a carry out of bit 31. Otherwise it is low.
- R5: While en is low, phase_o holds its value and ovf_o is low.
- R6: sin_o is a 3-bit two's complement level chosen by k = phase_o[31:29]. For k = 0 to 7 the levels are +1, +2, +2, +1, -1, -2, -2, -1.
- R7: cos_o uses the same table as sin_o at index (k+2) mod 8. For k = 0 to 7 the levels are +2, +1, -1, -2, -2, -1, +1, +2.
- R8: A negative correction lowers the word with wrap-around. For example, bias 0 with correction -1 gives the word 0xFFFFFFFF, so the phase falls by one each clock and the carry occurs on every step except the one that starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable for the accumulator |
| bias_i | input | 32 | Nominal-rate frequency bias |
| corr_i | input | 24 | Signed loop correction |
| phase_o | output | 32 | Accumulator phase |
| ovf_o | output | 1 | One-clock strobe on each accumulator wrap |
| sin_o | output | 3 | Signed sine level |
| cos_o | output | 3 | Signed cosine level |

## Verification
The assertions assume that en, bias_i and corr_i are known and stable around every rising edge once reset is released. They also assume that reset is held for at least two clocks, so that the two-cycle look-back on the frequency word never reaches before time zero. The stimulus drives every input on the falling edge and starts with several reset clocks. It keeps corr_i inside its 24-bit signed range, including the extreme value -1 used with a zero bias. The quadrature and sign checks hold for every phase, so the stimulus sweeps all eight table indices.

// File: rtl/nco_pkg.sv
// Package nco_pkg
// Shared widths and the level mapping used by the carrier oscillator.
// Assumes an index of at least 3 bits and an amplitude of at least 3 bits.
package nco_pkg;

    localparam int unsigned NCO_PHASE_W = 32;
    localparam int unsigned NCO_CORR_W  = 24;
    localparam int unsigned NCO_IDX_W   = 3;
    localparam int unsigned NCO_AMP_W   = 3;

    // Maps a table index to a signed level of +-1 or +-2 (sine shape).
    function automatic logic signed [NCO_AMP_W-1:0] level_of(
        input logic [NCO_IDX_W-1:0] idx
    );
        logic negative;
        logic inner;
        logic signed [NCO_AMP_W-1:0] mag;
        negative = idx[NCO_IDX_W-1];
        inner    = idx[NCO_IDX_W-2] ^ idx[NCO_IDX_W-3];
        mag      = inner ? NCO_AMP_W'(2) : NCO_AMP_W'(1);
        return negative ? -mag : mag;
    endfunction

endpackage

// File: rtl/nco_freq_word.sv
// Module nco_freq_word
// Adds the signed correction, sign-extended, to the bias word (mod 2^PHASE_W)
// and registers the result on every clock. Assumes CORR_W <= PHASE_W.
module nco_freq_word #(
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned CORR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] bias_i,
    input  logic [CORR_W-1:0]  corr_i,
    output logic [PHASE_W-1:0] word_o
);
    localparam int unsigned EXT_W = PHASE_W - CORR_W;

    logic [PHASE_W-1:0] corr_ext;
    logic [PHASE_W-1:0] word_d;

    // Sign-extends the correction and forms the modular sum.
    always_comb begin
        corr_ext = {{EXT_W{corr_i[CORR_W-1]}}, corr_i};
        word_d   = bias_i + corr_ext;
    end

    // Registers the frequency word; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else begin
            word_o <= word_d;
        end
    end
endmodule

// File: rtl/nco_phase_accum.sv
// Module nco_phase_accum
// Phase accumulator: adds the frequency word on enabled clocks and flags the
// carry out of the top bit in the same clock the wrapped phase appears.
// Assumes the frequency word is already registered.
module nco_phase_accum #(
    parameter int unsigned PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] word_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o
);
    logic [PHASE_W:0] sum;

    // Forms the next phase with its carry bit.
    always_comb begin
        sum = {1'b0, phase_o} + {1'b0, word_i};
    end

    // Updates phase and wrap strobe; holds while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
            wrap_o  <= 1'b0;
        end else if (en) begin
            phase_o <= sum[PHASE_W-1:0];
            wrap_o  <= sum[PHASE_W];
        end else begin
            wrap_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/nco_trig_map.sv
// Module nco_trig_map
// Converts the top phase bits to a signed level. OFFSET rotates the index so
// one module serves both sine (0) and cosine (a quarter cycle).
// Assumes IDX_W is at least 3.
module nco_trig_map #(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned AMP_W  = 3,
    parameter int unsigned OFFSET = 0
) (
    input  logic [IDX_W-1:0]        idx_i,
    output logic signed [AMP_W-1:0] level_o
);
    import nco_pkg::*;

    localparam logic [IDX_W-1:0] ROT = IDX_W'(OFFSET);

    logic [IDX_W-1:0] idx_rot;

    // Rotates the index and looks up the level.
    always_comb begin
        idx_rot = idx_i + ROT;
        level_o = AMP_W'(level_of(idx_rot));
    end
endmodule

// File: rtl/carrier_nco.sv
// Module carrier_nco
// Biased carrier oscillator: registered bias+correction word, phase
// accumulator with wrap strobe, and sine/cosine level maps.
// Assumes synchronous inputs; reset is synchronous, active low.
module carrier_nco #(
    parameter int unsigned PHASE_W = nco_pkg::NCO_PHASE_W,
    parameter int unsigned CORR_W  = nco_pkg::NCO_CORR_W,
    parameter int unsigned IDX_W   = nco_pkg::NCO_IDX_W,
    parameter int unsigned AMP_W   = nco_pkg::NCO_AMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] bias_i,
    input  logic [CORR_W-1:0]  corr_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               ovf_o,
    output logic [AMP_W-1:0]   sin_o,
    output logic [AMP_W-1:0]   cos_o
);
    localparam int unsigned QUARTER = 1 << (IDX_W - 2);
    localparam int unsigned NUM_MAP = 2;

    logic [PHASE_W-1:0] word_q;
    logic [IDX_W-1:0]   idx;
    logic [AMP_W-1:0]   levels [NUM_MAP];

    nco_freq_word #(
        .PHASE_W (PHASE_W),
        .CORR_W  (CORR_W)
    ) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .bias_i (bias_i),
        .corr_i (corr_i),
        .word_o (word_q)
    );

    nco_phase_accum #(
        .PHASE_W (PHASE_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .word_i  (word_q),
        .phase_o (phase_o),
        .wrap_o  (ovf_o)
    );

    // Takes the table index from the top phase bits.
    always_comb begin
        idx = phase_o[PHASE_W-1 -: IDX_W];
    end

    // One map per output: entry 0 is sine, entry 1 is cosine.
    for (genvar g = 0; g < NUM_MAP; g++) begin : g_map
        nco_trig_map #(
            .IDX_W  (IDX_W),
            .AMP_W  (AMP_W),
            .OFFSET (g * QUARTER)
        ) u_map (
            .idx_i   (idx),
            .level_o (levels[g])
        );
    end

    // Routes the map results to the ports.
    always_comb begin
        sin_o = levels[0];
        cos_o = levels[1];
    end
endmodule

// File: rtl/carrier_nco_chk.sv
// Module carrier_nco_chk
// Assertion checker bound to carrier_nco; observes ports only.
module carrier_nco_chk #(
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned CORR_W  = 24,
    parameter int unsigned AMP_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [PHASE_W-1:0] bias_i,
    input logic [CORR_W-1:0]  corr_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               ovf_o,
    input logic [AMP_W-1:0]   sin_o,
    input logic [AMP_W-1:0]   cos_o
);
    logic [PHASE_W-1:0] word_in;
    logic signed [AMP_W-1:0] s_sin;
    logic signed [AMP_W-1:0] s_cos;
    logic [AMP_W-1:0] abs_sin;
    logic [AMP_W-1:0] abs_cos;

    // Port-level view of the requested word and level magnitudes.
    always_comb begin
        word_in = bias_i + {{(PHASE_W-CORR_W){corr_i[CORR_W-1]}}, corr_i};
        s_sin   = sin_o;
        s_cos   = cos_o;
        abs_sin = s_sin[AMP_W-1] ? AMP_W'(-s_sin) : sin_o;
        abs_cos = s_cos[AMP_W-1] ? AMP_W'(-s_cos) : cos_o;
    end

    // R1: first clock out of reset shows zero phase and no strobe.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase_o == '0) && !ovf_o);

    // R2 and R3: phase steps by the word requested two clocks earlier.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(rst_n) && $past(rst_n, 2))
        |-> phase_o == $past(phase_o) + $past(word_in, 2));

    // R4: strobe exactly when the enabled step wrapped.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(rst_n)) |-> (ovf_o == (phase_o < $past(phase_o))));

    // R5: disabled clock holds phase and keeps strobe low.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && $past(rst_n)) |-> ($stable(phase_o) && !ovf_o));

    // R6: sine sign follows the top phase bit.
    a_r6_sin_sign: assert property (@(posedge clk) disable iff (!rst_n)
        s_sin[AMP_W-1] == phase_o[PHASE_W-1]);

    // R7: sine and cosine never share a magnitude.
    a_r7_quadrature: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_sin != abs_cos) && ($countones({abs_sin == AMP_W'(1), abs_cos == AMP_W'(1)}) == 1));
endmodule

bind carrier_nco carrier_nco_chk #(
    .PHASE_W (PHASE_W),
    .CORR_W  (CORR_W),
    .AMP_W   (AMP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .bias_i  (bias_i),
    .corr_i  (corr_i),
    .phase_o (phase_o),
    .ovf_o   (ovf_o),
    .sin_o   (sin_o),
    .cos_o   (cos_o)
);

// File: tb/test_carrier_nco.sv
// Scoreboard bench for carrier_nco: a driver task models each clock and
// queues the expected outputs; a monitor compares after each rising edge.
module test_carrier_nco;

    typedef struct {
        logic [31:0]       ph;
        logic              ov;
        logic signed [2:0] s;
        logic signed [2:0] c;
        string             tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] bias_i = '0;
    logic [23:0] corr_i = '0;
    logic [31:0] phase_o;
    logic        ovf_o;
    logic [2:0]  sin_o;
    logic [2:0]  cos_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    item_t       sb_q[$];
    logic [31:0] m_phase = '0;
    logic [31:0] m_freq = '0;

    carrier_nco i_carrier_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .bias_i  (bias_i),
        .corr_i  (corr_i),
        .phase_o (phase_o),
        .ovf_o   (ovf_o),
        .sin_o   (sin_o),
        .cos_o   (cos_o)
    );

    always #5 clk = ~clk;

    // R6 table
    function automatic logic signed [2:0] exp_sin(input logic [2:0] k);
        case (k)
            3'd0: return 3'sd1;
            3'd1: return 3'sd2;
            3'd2: return 3'sd2;
            3'd3: return 3'sd1;
            3'd4: return -3'sd1;
            3'd5: return -3'sd2;
            3'd6: return -3'sd2;
            default: return -3'sd1;
        endcase
    endfunction

    // R7 table
    function automatic logic signed [2:0] exp_cos(input logic [2:0] k);
        case (k)
            3'd0: return 3'sd2;
            3'd1: return 3'sd1;
            3'd2: return -3'sd1;
            3'd3: return -3'sd2;
            3'd4: return -3'sd2;
            3'd5: return -3'sd1;
            3'd6: return 3'sd1;
            default: return 3'sd2;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one clock of stimulus and queues the expected result.
    task automatic step(input logic r, input logic e, input logic [31:0] b,
                        input logic [23:0] c, input string tag);
        item_t it;
        logic [32:0] sum;
        logic ov;
        @(negedge clk);
        rst_n  = r;
        en     = e;
        bias_i = b;
        corr_i = c;
        ov = 1'b0;
        if (!r) begin
            m_phase = '0;
            m_freq  = '0;
        end else begin
            if (e) begin
                sum     = {1'b0, m_phase} + {1'b0, m_freq};
                ov      = sum[32];
                m_phase = sum[31:0];
            end
            m_freq = b + {{8{c[23]}}, c};
        end
        it.ph  = m_phase;
        it.ov  = ov;
        it.s   = exp_sin(m_phase[31:29]);
        it.c   = exp_cos(m_phase[31:29]);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: pops one expected item per clock and compares.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.tag, "phase", phase_o, it.ph);
                chk(it.tag, "ovf", {31'd0, ovf_o}, {31'd0, it.ov});
                chk("R6", "sin", {{29{sin_o[2]}}, sin_o}, {{29{it.s[2]}}, it.s});
                chk("R7", "cos", {{29{cos_o[2]}}, cos_o}, {{29{it.c[2]}}, it.c});
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 32'h1234_5678, 24'h000100, "R1");
        // R2 latency: first step uses the zero word; then R3 steps of 2^29, R4 wrap every 8
        step(1'b1, 1'b1, 32'h2000_0000, 24'h0, "R2");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 32'h2000_0000, 24'h0, "R4");
        // R5: disabled clocks hold while bias changes
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'h0F00_0000 + i, 24'h7FFFFF, "R5");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 32'h0F00_0000, 24'h7FFFFF, "R3");
        // R8: negative correction with a nominal-rate bias
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 32'hD17_3E50, 24'hF00000, "R8");
        // R1: reset in mid-run
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 32'h0, 24'hFFFFFF, "R1");
        // R8: bias 0, correction -1 gives word all ones
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 32'h0, 24'hFFFFFF, "R8");
        // R4: word above half scale, wraps on consecutive clocks
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 32'hC000_0000, 24'h0, "R4");
        // R3: bias for a sweep of all indices by 3/8 turn steps
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 32'h6000_0000, 24'h0, "R3");
        step(1'b1, 1'b0, 32'h0, 24'h0, "R5");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        finish_run();
    end
endmodule